// File: doc/BRIEF.md
# Self-Terminating Step-Pulse Write Sequencer for Resistive Memory

This block programs one resistive memory cell by driving a train of voltage step pulses into an external write driver, and it never inserts a read-verify pass. An external current detector watches the write current and raises a one-bit flag once the cell resistance has switched. The sequencer stops the stimulus the moment that flag is seen and reports success. If the programmed list of steps runs out first, it reports failure.

The two operations are shaped differently. A set operation (low-resistance write) begins at a high step level and walks downward. A reset operation (high-resistance write) begins low and only ever walks upward, because a large first reset step harms endurance. For each operation the start level, the step size, the number of steps and the per-step pulse length in clock cycles come from configuration inputs. At a 50 MHz clock, 3 cycles gives the usual 60 ns set pulse and 50 cycles gives the usual 1 us reset pulse. The configuration must stay stable while the block is busy.

Top module: `cell_write_seq`

## Requirements
- R1: After a synchronous active-low reset, `wr_en`, `busy`, `done`, `pass` and `wr_level` are all 0, and `wr_en` and `wr_level` stay 0 whenever `busy` is low.
- R2: A `start` high while idle, sampled on a rising edge, makes `busy` and `wr_en` high from that edge on. `op_sel` picks the operation (0 = set, 1 = reset), and `wr_level` takes that operation's start level.
- R3: During a set, each step drives `wr_en` for exactly `cfg_set_len` cycles (0 counts as 1). The next step's level is the previous level minus `cfg_set_dec`, saturating at 0.
- R4: During a reset, each step lasts `cfg_rst_len` cycles (0 counts as 1). The next level is the previous level plus `cfg_rst_inc`, saturating at 15, so the level never falls.
- R5: `fb_raw` passes through two synchronizing flops. When it is first seen high at rising edge E while busy, `wr_en` falls at edge E+2, even mid-step. In that cycle `done` is high with `pass` = 1.
- R6: When synchronized feedback and the end of a step (including the final step) fall on the same edge, feedback wins: the operation ends with `pass` = 1.
- R7: If the last of `cfg_*_num` steps ends (0 counts as 1) with no feedback, `wr_en` falls on that edge. `done` is then high for that cycle with `pass` = 0.
- R8: A `start` pulse, or a change of `op_sel`, while `busy` is high has no effect on the levels, the timing or the outcome of the running operation.
- R9: `done` is high for exactly one cycle per operation. `pass` holds its value until the next accepted start. `busy` is low while `done` is high, and `wr_level` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_sel | input | 1 | 0 = set, 1 = reset |
| cfg_set_lvl | input | 4 | First level of a set operation |
| cfg_set_dec | input | 4 | Level decrement per set step |
| cfg_set_num | input | 4 | Number of set steps |
| cfg_set_len | input | LEN_W | Set step length in cycles |
| cfg_rst_lvl | input | 4 | First level of a reset operation |
| cfg_rst_inc | input | 4 | Level increment per reset step |
| cfg_rst_num | input | 4 | Number of reset steps |
| cfg_rst_len | input | LEN_W | Reset step length in cycles |
| fb_raw | input | 1 | Asynchronous switched flag from the current detector |
| wr_en | output | 1 | Write stimulus enable to the driver |
| wr_level | output | 4 | Step level code to the driver |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | 1 = ended on feedback, 0 = steps exhausted |

## Verification
The hardest situation to reach is feedback that lands on exactly the edge where a step, or the whole operation, would have ended. The synchronizer delay has to be counted back from that boundary. The stimulus raises `fb_raw` a known number of cycles after the start so that the synchronized flag meets the end of the final step, which shows that feedback takes priority. Mid-step cut-offs, level saturation in both directions, zero-length and zero-count settings, and start pulses while busy are driven alongside. A behavioural model is compared with every output on every cycle.

// File: rtl/cws_pkg.sv
// Shared types and the level stepping rule for the write sequencer.
// Assumes a 4-bit level code; set walks down, reset walks up, both saturate.
package cws_pkg;
    localparam int LVL_W = 4;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic {OP_SET = 1'b0, OP_RESET = 1'b1} op_e;

    typedef enum logic {ST_IDLE = 1'b0, ST_DRIVE = 1'b1} st_e;

    // Next step level: down for set (floor 0), up for reset (ceiling all-ones).
    function automatic lvl_t next_level(lvl_t cur, lvl_t delta, op_e op);
        logic [LVL_W:0] sum;
        sum = {1'b0, cur} + {1'b0, delta};
        if (op == OP_RESET)
            return sum[LVL_W] ? {LVL_W{1'b1}} : sum[LVL_W-1:0];
        else
            return (cur > delta) ? (cur - delta) : '0;
    endfunction
endpackage

// File: rtl/cws_fb_sync.sv
// Synchronizer for the asynchronous switched flag from the current detector.
// Assumes STAGES >= 2; the output lags the input by STAGES rising edges.
module cws_fb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the flag through the flop chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

    // R5: a rising synchronized flag was present at the input STAGES edges earlier.
    a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(async_in, STAGES));
endmodule

// File: rtl/cws_pulse_timer.sv
// Counts the cycles of the current step and flags its last cycle.
// Assumes len is stable while run is high; a length of 0 counts as 1.
module cws_pulse_timer #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cnt;

    // Last cycle of the step when the count reaches len-1.
    always_comb begin
        if (len == '0) last = 1'b1;
        else           last = (cnt >= len - 1'b1);
    end

    // Advance the count inside a step; restart at each new step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)  cnt <= '0;
        else if (run && !last) cnt <= cnt + 1'b1;
    end

    // R3: the count never runs past the programmed length.
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (run && len != '0) |-> (cnt < len));
endmodule

// File: rtl/cws_step_gen.sv
// Holds the current step level and step index, and says when the final step runs.
// Assumes num is stable during an operation; a count of 0 counts as 1.
module cws_step_gen
    import cws_pkg::*;
#(
    parameter int NUM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             clear,
    input  op_e              op,
    input  lvl_t             first,
    input  lvl_t             delta,
    input  logic [NUM_W-1:0] num,
    output lvl_t             level,
    output logic             final_step
);
    logic [NUM_W-1:0] idx;

    // Final step once the index reaches num-1.
    always_comb begin
        if (num == '0) final_step = 1'b1;
        else           final_step = (idx >= num - 1'b1);
    end

    // Load the first level, step it per the operation, or clear it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            level <= '0;
            idx   <= '0;
        end else if (load) begin
            level <= first;
            idx   <= '0;
        end else if (advance) begin
            level <= next_level(level, delta, op);
            idx   <= idx + 1'b1;
        end
    end

    // R3: a set step never raises the level.
    a_r3_set_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !clear && op == OP_SET) |=> (level <= $past(level)));

    // R4: a reset step never lowers the level.
    a_r4_reset_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !clear && op == OP_RESET) |=> (level >= $past(level)));
endmodule

// File: rtl/cell_write_seq.sv
// Step-pulse write sequencer that ends on live current feedback.
// Accepts a start when idle, drives step levels until feedback or the last
// step runs out, then pulses done with pass/fail.
// Assumes the configuration is stable while busy and fb_raw is asynchronous.
module cell_write_seq
    import cws_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int NUM_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_sel,
    input  logic [3:0]       cfg_set_lvl,
    input  logic [3:0]       cfg_set_dec,
    input  logic [NUM_W-1:0] cfg_set_num,
    input  logic [LEN_W-1:0] cfg_set_len,
    input  logic [3:0]       cfg_rst_lvl,
    input  logic [3:0]       cfg_rst_inc,
    input  logic [NUM_W-1:0] cfg_rst_num,
    input  logic [LEN_W-1:0] cfg_rst_len,
    input  logic             fb_raw,
    output logic             wr_en,
    output logic [3:0]       wr_level,
    output logic             busy,
    output logic             done,
    output logic             pass
);
    st_e  st;
    op_e  op_q, op_act;
    logic wr_en_q, done_q, pass_q;
    logic fb_s, step_last, final_step;
    logic go, hit, out_fail, adv;
    lvl_t first_lvl, delta_lvl, level;
    logic [NUM_W-1:0] num_sel;
    logic [LEN_W-1:0] len_sel;

    // Decisions for this cycle; feedback outranks a step boundary.
    always_comb begin
        go       = (st == ST_IDLE) && start;
        hit      = (st == ST_DRIVE) && fb_s;
        out_fail = (st == ST_DRIVE) && !fb_s && step_last && final_step;
        adv      = (st == ST_DRIVE) && !fb_s && step_last && !final_step;
        op_act   = go ? op_e'(op_sel) : op_q;
    end

    // Pick the configuration of the active operation.
    always_comb begin
        if (op_act == OP_RESET) begin
            first_lvl = cfg_rst_lvl;
            delta_lvl = cfg_rst_inc;
            num_sel   = cfg_rst_num;
            len_sel   = cfg_rst_len;
        end else begin
            first_lvl = cfg_set_lvl;
            delta_lvl = cfg_set_dec;
            num_sel   = cfg_set_num;
            len_sel   = cfg_set_len;
        end
    end

    cws_fb_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fb_raw),
        .sync_out (fb_s)
    );

    cws_pulse_timer #(.LEN_W(LEN_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (go || adv),
        .run   (st == ST_DRIVE),
        .len   (len_sel),
        .last  (step_last)
    );

    cws_step_gen #(.NUM_W(NUM_W)) i_steps (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (go),
        .advance    (adv),
        .clear      (hit || out_fail),
        .op         (op_act),
        .first      (first_lvl),
        .delta      (delta_lvl),
        .num        (num_sel),
        .level      (level),
        .final_step (final_step)
    );

    // Control state: launch, cut off on feedback, or stop when steps run out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            op_q    <= OP_SET;
            wr_en_q <= 1'b0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                st      <= ST_DRIVE;
                op_q    <= op_e'(op_sel);
                wr_en_q <= 1'b1;
                pass_q  <= 1'b0;
            end else if (hit || out_fail) begin
                st      <= ST_IDLE;
                wr_en_q <= 1'b0;
                done_q  <= 1'b1;
                pass_q  <= hit;
            end
        end
    end

    assign wr_en    = wr_en_q;
    assign wr_level = level;
    assign busy     = (st == ST_DRIVE);
    assign done     = done_q;
    assign pass     = pass_q;

    // R1: no stimulus and a zero level whenever idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_en && wr_level == '0));

    // R2: an idle start launches the stimulus on the next cycle.
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && wr_en));

    // R5: synchronized feedback while busy ends the operation with a pass.
    a_r5_cutoff: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fb_s) |=> (!wr_en && done && pass));

    // R7: running out of steps ends the operation with a fail.
    a_r7_exhaust_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fb_s && step_last && final_step) |=> (!wr_en && done && !pass));

    // R8: a start while busy and mid-step leaves the level untouched.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !fb_s && !step_last) |=> (busy && $stable(wr_level)));

    // R9: done is a single-cycle pulse and comes with busy low.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/test_cell_write_seq.sv
// Bench for cell_write_seq: a behavioural model checked every cycle plus directed checks.
module test_cell_write_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_sel = 1'b0;
    logic [3:0]  cfg_set_lvl = 4'd12, cfg_set_dec = 4'd3, cfg_set_num = 4'd4;
    logic [11:0] cfg_set_len = 12'd3;
    logic [3:0]  cfg_rst_lvl = 4'd2, cfg_rst_inc = 4'd5, cfg_rst_num = 4'd4;
    logic [11:0] cfg_rst_len = 12'd50;
    logic        fb_raw = 1'b0;
    logic        wr_en, busy, done, pass;
    logic [3:0]  wr_level;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    cell_write_seq i_cell_write_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .cfg_set_lvl(cfg_set_lvl), .cfg_set_dec(cfg_set_dec),
        .cfg_set_num(cfg_set_num), .cfg_set_len(cfg_set_len),
        .cfg_rst_lvl(cfg_rst_lvl), .cfg_rst_inc(cfg_rst_inc),
        .cfg_rst_num(cfg_rst_num), .cfg_rst_len(cfg_rst_len),
        .fb_raw(fb_raw), .wr_en(wr_en), .wr_level(wr_level),
        .busy(busy), .done(done), .pass(pass)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int m_busy = 0, m_done = 0, m_pass = 0, m_lvl = 0;
    int m_t = 0, m_i = 0, m_n = 1, m_w = 1, m_d = 0, m_op = 0;
    int m_f1 = 0, m_f2 = 0;
    always @(posedge clk) begin
        int fbs;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_pass = 0; m_lvl = 0;
            m_t = 0; m_i = 0; m_f1 = 0; m_f2 = 0;
        end else begin
            fbs = m_f2; m_f2 = m_f1; m_f1 = fb_raw;
            m_done = 0;
            if (m_busy == 0) begin
                if (start) begin
                    m_busy = 1; m_pass = 0; m_op = op_sel; m_t = 0; m_i = 0;
                    m_lvl = op_sel ? cfg_rst_lvl : cfg_set_lvl;
                    m_d   = op_sel ? cfg_rst_inc : cfg_set_dec;
                    m_n   = op_sel ? cfg_rst_num : cfg_set_num;
                    m_w   = op_sel ? cfg_rst_len : cfg_set_len;
                    if (m_n == 0) m_n = 1;
                    if (m_w == 0) m_w = 1;
                end
            end else if (fbs != 0) begin
                m_busy = 0; m_done = 1; m_pass = 1; m_lvl = 0;
            end else if (m_t >= m_w - 1) begin
                if (m_i >= m_n - 1) begin
                    m_busy = 0; m_done = 1; m_pass = 0; m_lvl = 0;
                end else begin
                    m_i++; m_t = 0;
                    m_lvl = m_op ? ((m_lvl + m_d > 15) ? 15 : m_lvl + m_d)
                                 : ((m_lvl > m_d) ? m_lvl - m_d : 0);
                end
            end else begin
                m_t++;
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "wr_en",    wr_en,    m_busy);
            chk(cur_req, "busy",     busy,     m_busy);
            chk(cur_req, "wr_level", wr_level, m_lvl);
            chk(cur_req, "done",     done,     m_done);
            chk(cur_req, "pass",     pass,     m_pass);
        end
    end

    // Run one operation; fb_at = cycle to raise feedback (-1 none), poke_at = busy start.
    task automatic run_op(input logic op, input int fb_at, input int poke_at,
                          input int exp_pass, input int exp_high, input int exp_last,
                          input string req);
        int cyc = 0, high = 0, last_lvl = -1, seen_pass = -1;
        logic got = 1'b0;
        cur_req = req;
        op_sel = op;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (fb_at == 0) fb_raw = 1'b1;
        if (wr_en) begin high++; last_lvl = wr_level; end
        while (!got && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc == fb_at) fb_raw = 1'b1;
            if (cyc == poke_at) begin start = 1'b1; op_sel = ~op; end
            else begin start = 1'b0; op_sel = op; end
            if (wr_en) begin high++; last_lvl = wr_level; end
            if (done) begin got = 1'b1; seen_pass = pass; end
        end
        fb_raw = 1'b0;
        start = 1'b0;
        op_sel = op;
        chk(req, "done seen", got, 1);
        chk(req, "pass", seen_pass, exp_pass);
        chk(req, "wr_en cycles", high, exp_high);
        chk(req, "last level", last_lvl, exp_last);
        @(negedge clk);
        chk("R9", "done after pulse", done, 0);
        chk("R9", "pass held", pass, exp_pass);
        chk("R9", "idle level", wr_level, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset wr_en", wr_en, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset pass", pass, 0);
        chk("R1", "reset level", wr_level, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R7: set 12 down by 3, four steps of 3 cycles, no feedback.
        run_op(1'b0, -1, -1, 0, 12, 3, "R3_R7");
        // R3: saturation at 0.
        cfg_set_lvl = 4'd5; cfg_set_dec = 4'd4; cfg_set_num = 4'd3; cfg_set_len = 12'd2;
        run_op(1'b0, -1, -1, 0, 6, 0, "R3");
        // R4: reset 2 up by 5, saturating at 15.
        cfg_rst_len = 12'd4;
        run_op(1'b1, -1, -1, 0, 16, 15, "R4");
        // R5: feedback mid-step cuts the set short.
        cfg_set_lvl = 4'd12; cfg_set_dec = 4'd3; cfg_set_num = 4'd4; cfg_set_len = 12'd3;
        run_op(1'b0, 5, -1, 1, 8, 6, "R5");
        // R6: feedback lands on the final step end and wins.
        cfg_set_num = 4'd2;
        run_op(1'b0, 3, -1, 1, 6, 9, "R6");
        // R6: feedback lands on a step boundary.
        run_op(1'b0, 0, -1, 1, 3, 12, "R6");
        // R8: start and op change while busy are ignored.
        cfg_set_num = 4'd4;
        run_op(1'b0, -1, 4, 0, 12, 3, "R8");
        // R3 R7: zero length and zero count both count as one.
        cfg_set_len = 12'd0; cfg_set_num = 4'd0;
        run_op(1'b0, -1, -1, 0, 1, 12, "R7");
        // R2 R5: long reset pulses cut by feedback.
        cfg_rst_len = 12'd50; cfg_rst_num = 4'd3;
        run_op(1'b1, 70, -1, 1, 73, 7, "R2_R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule